// File: doc/BRIEF.md
# Strobed Input Port Pair with Handshake Status

The block holds two parallel input ports, A and B. Each port latches its external data word when its active-low strobe falls, and it raises a buffer-full flag. If that port's interrupt enable is set, an interrupt request goes high on a dedicated output pin. A host reads the latched words from two data addresses. A third address returns a status word that packs the buffer-full flags, the interrupt enables and the interrupt requests of both ports. The same status word also carries two general-purpose bits.

The host uses one write-only address for two kinds of word. If bit 7 of the word is set, the word defines the mode: it chooses which ports use the strobed input handshake, and whether the two general-purpose bits are inputs or outputs. If bit 7 is clear, the word sets or clears one bit of the status port. This is how the host writes the interrupt enables and the general-purpose output bits. Reading a port's data clears that port's buffer-full flag, and the port's interrupt request drops with it.

Top module: `strobed_in_ctrl`

## Requirements
- R1: After reset, neither port uses the strobed handshake. Both general-purpose bits are inputs, so `pc_hi_oe` is 00. All buffer-full flags, enables and latches are zero, and `irq_a` and `irq_b` are low.
- R2: A write to address 3 with bit 7 set is a mode word. Port A uses the strobed input handshake only when bits 6:5 are 01 and bit 4 is 1. Port B uses it only when bits 2 and 1 are both 1. Bit 3 set makes status bits 7:6 inputs, and bit 3 clear makes them outputs. A mode word also clears both buffer-full flags, both enables and both general-purpose output latches.
- R3: While a port is in strobed input mode, the first clock edge that samples its strobe low after a high sample loads that port's data into its latch and sets its buffer-full flag. Both changes are visible right after that edge. Holding the strobe low loads no further data.
- R4: A read at address 0 (port A) or address 1 (port B) returns that port's latch in the same cycle. The read clears that port's buffer-full flag after the clock edge and leaves the other port's flag unchanged. If a strobe is detected in the same cycle, the strobe wins: the new data is loaded and the flag stays set.
- R5: A write to address 3 with bit 7 clear is a set/reset command. Bits 3:1 select a status bit and bit 0 gives its new value. Selecting bit 4 writes the port A enable, and selecting bit 2 writes the port B enable.
- R6: Each port's interrupt request, on its pin and in the status word, is high exactly when that port's buffer-full flag and its enable are both high.
- R7: A read at address 2 returns a status word with this layout: bit 7 and bit 6 are the general-purpose bits, bit 5 is port A buffer-full, bit 4 is port A enable, bit 3 is port A request, bit 2 is port B enable, bit 1 is port B buffer-full, and bit 0 is port B request.
- R8: When the general-purpose bits are outputs, only set/reset commands selecting bit 7 or bit 6 change them. They drive `pc_hi_out[1]` (bit 7) and `pc_hi_out[0]` (bit 6), with `pc_hi_oe` at 11, and the status word shows them. When the bits are inputs, the status word shows `pc_hi_in` instead. Set/reset commands selecting bits 0, 1, 3 or 5 change nothing.
- R9: A strobe on a port that is not in strobed input mode leaves that port's latch and buffer-full flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Host address: 0 port A, 1 port B, 2 status, 3 control |
| bus_wr | input | 1 | Host write strobe, one cycle per write |
| bus_rd | input | 1 | Host read strobe, one cycle per read |
| bus_wdata | input | DW | Host write data |
| bus_rdata | output | DW | Host read data, combinational from `bus_addr` |
| stb_a_n | input | 1 | Port A active-low strobe |
| stb_b_n | input | 1 | Port B active-low strobe |
| pa_in | input | DW | Port A external data |
| pb_in | input | DW | Port B external data |
| pc_hi_in | input | 2 | General-purpose status bits 7:6 when they are inputs |
| pc_hi_out | output | 2 | General-purpose status bits 7:6 output latches |
| pc_hi_oe | output | 2 | Output enable for bits 7:6 |
| irq_a | output | 1 | Port A interrupt request |
| irq_b | output | 1 | Port B interrupt request |

## Verification
- **Data sweep.** All 256 data values go through port A, and a scrambled copy of each value goes through port B at the same time. The two enables are stepped through all four combinations, so the request pins and the status word are checked against every pairing of buffer-full and enable. Because the two ports carry different data, swapped latches or crossed status bits show up.
- **Set/reset sweep.** The bench tries every select code with both values. This separates the four live selects from the four that must have no effect.
- **Strobe and read timing.** A strobe held low over several cycles while the data changes shows that data is loaded only on the falling edge. A read in the same cycle as a strobe shows that the strobe takes priority.
- **Mode words.** Mode words that put one port in the wrong mode or direction show that a strobe on an unconfigured port is ignored. Toggling the direction of the general-purpose bits separates the input view of those bits from the output view.

// File: rtl/sip_pkg.sv
package sip_pkg;

    localparam logic [1:0] ADDR_A   = 2'd0;
    localparam logic [1:0] ADDR_B   = 2'd1;
    localparam logic [1:0] ADDR_ST  = 2'd2;
    localparam logic [1:0] ADDR_CTL = 2'd3;

    localparam int unsigned NPORT = 2;

    typedef struct packed {
        logic a_strobed;
        logic b_strobed;
        logic hi_input;
    } mode_t;

    typedef struct packed {
        mode_t      mode;
        logic [1:0] inte;
        logic [1:0] hi_out;
    } ctl_t;

endpackage

// File: rtl/sip_ctl.sv
module sip_ctl
    import sip_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_ctl,
    input  logic [DW-1:0] wdata,
    output mode_t         mode,
    output logic [1:0]    inte,
    output logic [1:0]    hi_out,
    output logic          mode_wr
);

    ctl_t ctl_d, ctl_q;

    assign mode_wr = wr_ctl && wdata[7];

    always_comb begin
        ctl_d = ctl_q;
        if (wr_ctl) begin
            if (wdata[7]) begin
                ctl_d.mode.a_strobed = (wdata[6:5] == 2'b01) && wdata[4];
                ctl_d.mode.b_strobed = wdata[2] && wdata[1];
                ctl_d.mode.hi_input  = wdata[3];
                ctl_d.inte           = 2'b00;
                ctl_d.hi_out         = 2'b00;
            end else begin
                case (wdata[3:1])
                    3'd4:    ctl_d.inte[0]   = wdata[0];
                    3'd2:    ctl_d.inte[1]   = wdata[0];
                    3'd6:    ctl_d.hi_out[0] = wdata[0];
                    3'd7:    ctl_d.hi_out[1] = wdata[0];
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q      <= '0;
            ctl_q.mode <= '{a_strobed: 1'b0, b_strobed: 1'b0, hi_input: 1'b1};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign mode   = ctl_q.mode;
    assign inte   = ctl_q.inte;
    assign hi_out = ctl_q.hi_out;

    // R5: set/reset on bit 4 writes port A enable
    a_r5_sr_inte_a: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && !wdata[7] && wdata[3:1] == 3'd4) |=> (inte[0] == $past(wdata[0])));

    // R2: mode word clears enables and output latches
    a_r2_mode_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && wdata[7]) |=> (inte == 2'b00 && hi_out == 2'b00));

    // R8: unused selects leave all control state alone
    a_r8_dead_selects: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && !wdata[7] && (wdata[3:1] == 3'd0 || wdata[3:1] == 3'd1 ||
                                 wdata[3:1] == 3'd3 || wdata[3:1] == 3'd5))
        |=> ($stable(inte) && $stable(hi_out) && $stable(mode)));

endmodule

// File: rtl/sip_port.sv
module sip_port #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          clr,
    input  logic          rd_clr,
    input  logic          stb_n,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          ibf
);

    typedef struct packed {
        logic          stb_prev;
        logic          ibf;
        logic [DW-1:0] data;
    } port_st_t;

    port_st_t st_d, st_q;
    logic     fall;

    assign fall = st_q.stb_prev && !stb_n;

    always_comb begin
        st_d          = st_q;
        st_d.stb_prev = stb_n;
        if (clr) begin
            st_d.ibf = 1'b0;
        end else if (en && fall) begin
            st_d.data = din;
            st_d.ibf  = 1'b1;
        end else if (rd_clr) begin
            st_d.ibf = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.stb_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.data;
    assign ibf  = st_q.ibf;

    // R3: falling strobe in strobed mode loads data and sets buffer-full
    a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && $fell(stb_n)) |=> (ibf && dout == $past(din)));

    // R4: a read without a competing strobe clears buffer-full
    a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !(en && $fell(stb_n))) |=> !ibf);

    // R9: latch holds while the port is not in strobed mode
    a_r9_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!en) |=> $stable(dout));

endmodule

// File: rtl/strobed_in_ctrl.sv
module strobed_in_ctrl
    import sip_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          stb_a_n,
    input  logic          stb_b_n,
    input  logic [DW-1:0] pa_in,
    input  logic [DW-1:0] pb_in,
    input  logic [1:0]    pc_hi_in,
    output logic [1:0]    pc_hi_out,
    output logic [1:0]    pc_hi_oe,
    output logic          irq_a,
    output logic          irq_b
);

    mode_t            mode;
    logic [1:0]       inte;
    logic [1:0]       hi_out;
    logic             mode_wr;

    logic [NPORT-1:0] en_v;
    logic [NPORT-1:0] stb_v;
    logic [NPORT-1:0] rd_v;
    logic [NPORT-1:0] ibf_v;
    logic [DW-1:0]    din_v  [NPORT];
    logic [DW-1:0]    dout_v [NPORT];
    logic [DW-1:0]    status;
    logic [1:0]       hi_view;

    sip_ctl #(.DW(DW)) i_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ctl  (bus_wr && bus_addr == ADDR_CTL),
        .wdata   (bus_wdata),
        .mode    (mode),
        .inte    (inte),
        .hi_out  (hi_out),
        .mode_wr (mode_wr)
    );

    assign en_v     = {mode.b_strobed, mode.a_strobed};
    assign stb_v    = {stb_b_n, stb_a_n};
    assign din_v[0] = pa_in;
    assign din_v[1] = pb_in;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        assign rd_v[p] = bus_rd && (bus_addr == 2'(p));
        sip_port #(.DW(DW)) i_port (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (en_v[p]),
            .clr    (mode_wr),
            .rd_clr (rd_v[p]),
            .stb_n  (stb_v[p]),
            .din    (din_v[p]),
            .dout   (dout_v[p]),
            .ibf    (ibf_v[p])
        );
    end

    assign irq_a     = ibf_v[0] && inte[0];
    assign irq_b     = ibf_v[1] && inte[1];
    assign pc_hi_out = hi_out;
    assign pc_hi_oe  = {2{~mode.hi_input}};
    assign hi_view   = mode.hi_input ? pc_hi_in : hi_out;

    always_comb begin
        status      = '0;
        status[7:0] = {hi_view, ibf_v[0], inte[0], irq_a, inte[1], ibf_v[1], irq_b};
    end

    always_comb begin
        case (bus_addr)
            ADDR_A:  bus_rdata = dout_v[0];
            ADDR_B:  bus_rdata = dout_v[1];
            ADDR_ST: bus_rdata = status;
            default: bus_rdata = '0;
        endcase
    end

    // R4/R6: reading port A without a competing strobe drops its request
    a_r6_read_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_A && !$fell(stb_a_n)) |=> !irq_a);

    // R6: a request pin can only rise after its port saw a strobe or an enable write
    a_r6_irq_b_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_b) |-> ($past(bus_wr) || $past(!stb_b_n)));

    // R8: output enables follow the direction chosen by the last mode word
    a_r8_oe_dir: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_CTL && bus_wdata[7]) |=> (pc_hi_oe == {2{~$past(bus_wdata[3])}}));

endmodule

// File: tb/test_strobed_in_ctrl.sv
module test_strobed_in_ctrl;

    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          stb_a_n = 1'b1;
    logic          stb_b_n = 1'b1;
    logic [DW-1:0] pa_in = '0;
    logic [DW-1:0] pb_in = '0;
    logic [1:0]    pc_hi_in = '0;
    logic [1:0]    pc_hi_out;
    logic [1:0]    pc_hi_oe;
    logic          irq_a;
    logic          irq_b;

    int nvec = 0;
    int nerr = 0;

    // bench model
    logic       m_en [2];
    logic       m_ibf [2];
    logic       m_inte [2];
    logic [7:0] m_lat [2];
    logic [1:0] m_hi_out;
    logic       m_hi_in;

    strobed_in_ctrl #(.DW(DW)) i_strobed_in_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .stb_a_n(stb_a_n), .stb_b_n(stb_b_n), .pa_in(pa_in), .pb_in(pb_in),
        .pc_hi_in(pc_hi_in), .pc_hi_out(pc_hi_out), .pc_hi_oe(pc_hi_oe),
        .irq_a(irq_a), .irq_b(irq_b)
    );

    always #5 clk = ~clk;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_status();
        logic [1:0] hv;
        hv = m_hi_in ? pc_hi_in : m_hi_out;
        return {hv, m_ibf[0], m_inte[0], m_ibf[0] & m_inte[0],
                m_inte[1], m_ibf[1], m_ibf[1] & m_inte[1]};
    endfunction

    task automatic ctl_write(input logic [7:0] w);
        bus_addr = 2'd3; bus_wdata = w; bus_wr = 1'b1;
        tick();
        bus_wr = 1'b0;
        if (w[7]) begin
            m_en[0] = (w[6:5] == 2'b01) && w[4];
            m_en[1] = w[2] && w[1];
            m_hi_in = w[3];
            m_ibf[0] = 1'b0; m_ibf[1] = 1'b0;
            m_inte[0] = 1'b0; m_inte[1] = 1'b0;
            m_hi_out = 2'b00;
        end else begin
            case (w[3:1])
                3'd4: m_inte[0] = w[0];
                3'd2: m_inte[1] = w[0];
                3'd6: m_hi_out[0] = w[0];
                3'd7: m_hi_out[1] = w[0];
                default: ;
            endcase
        end
    endtask

    task automatic set_reset(input logic [2:0] sel, input logic v);
        ctl_write({4'b0000, sel, v});
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        d = bus_rdata;
        tick();
        bus_rd = 1'b0;
        if (a < 2'd2) m_ibf[a] = 1'b0;
    endtask

    task automatic strobe(input int p, input logic [7:0] v);
        if (p == 0) begin pa_in = v; stb_a_n = 1'b0; end
        else        begin pb_in = v; stb_b_n = 1'b0; end
        tick();
        if (m_en[p]) begin m_lat[p] = v; m_ibf[p] = 1'b1; end
        stb_a_n = 1'b1; stb_b_n = 1'b1;
        tick();
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] rd;
        m_en[0] = 0; m_en[1] = 0; m_ibf[0] = 0; m_ibf[1] = 0;
        m_inte[0] = 0; m_inte[1] = 0; m_lat[0] = 0; m_lat[1] = 0;
        m_hi_out = 2'b00; m_hi_in = 1'b1;
        pc_hi_in = 2'b01;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();

        // R1: reset state
        bus_read(2'd2, rd);
        chk("R1 status", rd, 8'h40);
        chk("R1 oe", {6'd0, pc_hi_oe}, 8'h00);
        chk("R1 irq", {6'd0, irq_a, irq_b}, 8'h00);

        // R9: strobe ignored while not in strobed mode
        strobe(0, 8'h5A);
        bus_read(2'd2, rd);
        chk("R9 status after ignored strobe", rd, exp_status());
        bus_read(2'd0, rd);
        chk("R9 latch A untouched", rd, 8'h00);

        // R2: both ports strobed input, upper bits output
        ctl_write(8'hB6);
        chk("R2 oe output", {6'd0, pc_hi_oe}, 8'h03);
        bus_read(2'd2, rd);
        chk("R2 status after mode", rd, exp_status());

        // R5 and R8: every select with both values
        for (int s = 0; s < 8; s++) begin
            for (int v = 0; v < 2; v++) begin
                set_reset(3'(s), 1'(v));
                bus_read(2'd2, rd);
                chk("R5/R8 set-reset status", rd, exp_status());
                chk("R8 pc_hi_out", {6'd0, pc_hi_out}, {6'd0, m_hi_out});
            end
        end

        // R3, R4, R6, R7: full data sweep across enable combinations
        for (int d = 0; d < 256; d++) begin
            set_reset(3'd4, d[0]);
            set_reset(3'd2, d[1]);
            strobe(0, 8'(d));
            strobe(1, 8'(d) ^ 8'hA5);
            chk("R6 irq pins", {6'd0, irq_a, irq_b},
                {6'd0, m_ibf[0] & m_inte[0], m_ibf[1] & m_inte[1]});
            bus_read(2'd2, rd);
            chk("R7 status full", rd, exp_status());
            bus_read(2'd0, rd);
            chk("R4 read A data", rd, 8'(d));
            bus_read(2'd2, rd);
            chk("R4 read A clears only A", rd, exp_status());
            bus_read(2'd1, rd);
            chk("R4 read B data", rd, 8'(d) ^ 8'hA5);
            chk("R6 irq after reads", {6'd0, irq_a, irq_b}, 8'h00);
        end

        // R3: capture edge and hold-low behaviour
        set_reset(3'd4, 1'b1);
        pa_in = 8'h11; stb_a_n = 1'b0;
        #1;
        chk("R3 not before edge", {7'd0, irq_a}, 8'h00);
        tick();
        chk("R3 irq right after edge", {7'd0, irq_a}, 8'h01);
        pa_in = 8'h22;
        tick();
        tick();
        stb_a_n = 1'b1;
        tick();
        m_lat[0] = 8'h11; m_ibf[0] = 1'b1;
        bus_addr = 2'd0; #1;
        chk("R3 no recapture while low", bus_rdata, 8'h11);

        // R4: strobe and read in the same cycle, strobe wins
        bus_addr = 2'd0; bus_rd = 1'b1; pa_in = 8'h33; stb_a_n = 1'b0;
        #1;
        chk("R4 collision read old data", bus_rdata, 8'h11);
        tick();
        bus_rd = 1'b0; stb_a_n = 1'b1;
        m_lat[0] = 8'h33; m_ibf[0] = 1'b1;
        chk("R4 collision keeps irq", {7'd0, irq_a}, 8'h01);
        tick();
        bus_read(2'd0, rd);
        chk("R4 collision new data", rd, 8'h33);

        // R2: mode word clears buffer-full and enables
        strobe(1, 8'h77);
        ctl_write(8'hB6);
        bus_read(2'd2, rd);
        chk("R2 mode clears flags", rd, 8'h00);

        // R8: upper bits as inputs
        ctl_write(8'hBE);
        pc_hi_in = 2'b10;
        #1;
        chk("R8 oe input", {6'd0, pc_hi_oe}, 8'h00);
        set_reset(3'd7, 1'b1);
        bus_read(2'd2, rd);
        chk("R8 input view", rd, exp_status());
        ctl_write(8'hB6);
        bus_read(2'd2, rd);
        chk("R8 output view cleared", rd, exp_status());

        // R2/R9: port A direction output -> not strobed, B still strobed
        ctl_write(8'hA6);
        strobe(0, 8'hC3);
        strobe(1, 8'h3C);
        bus_read(2'd2, rd);
        chk("R9 A output dir ignored", rd, exp_status());
        bus_read(2'd0, rd);
        chk("R9 latch A kept", rd, m_lat[0]);
        bus_read(2'd1, rd);
        chk("R2 B still strobed", rd, 8'h3C);

        // R2/R9: port B mode 0 -> B ignored
        ctl_write(8'hB2);
        strobe(1, 8'h99);
        strobe(0, 8'h66);
        bus_read(2'd2, rd);
        chk("R9 B mode0 ignored", rd, exp_status());
        bus_read(2'd1, rd);
        chk("R9 latch B kept", rd, 8'h3C);
        bus_read(2'd0, rd);
        chk("R2 A strobed again", rd, 8'h66);

        summary();
        $finish;
    end

endmodule